// File: doc/BRIEF.md
# Byte and Nibble Crossbar Permutation Unit

This unit performs a data-dependent table lookup across the lanes of a register-width word. One operand, the table, is treated as a small array of elements. The other operand, the index word, is split into lanes of the same element width. Each lane holds an unsigned number that selects one table element, and that element is written into the same lane of the result. A one-bit form select picks either 8-bit elements (byte form) or 4-bit elements (nibble form). Every lane is looked up on its own. An index that points past the end of the table produces a zero lane.

The datapath width is a parameter, normally 32 or 64. The lookup is combinational and feeds a single output register. The result and its valid strobe appear on the clock edge after the input strobe. The unit sits next to an execute stage. That stage decodes the two crossbar instructions (R-type, funct7 0010100, opcode 0110011, funct3 100 for bytes and 010 for nibbles) and drives `op_nib` from them.

Top module: `xperm_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly those cycles that follow a rising clock edge at which `in_valid` was 1. It is 0 otherwise.
- R3: Byte form (`op_nib` = 0). Result lane i, bits 8i+7..8i, equals table byte k, bits 8k+7..8k. Here k is the unsigned value of `src_idx` bits 8i+7..8i.
- R4: Byte form. When 8·k is at least XLEN, result lane i is zero. On a 32-bit unit this covers every index from 4 to 255.
- R5: Nibble form (`op_nib` = 1). Result lane i, bits 4i+3..4i, equals table nibble k, bits 4k+3..4k. Here k is the unsigned value of `src_idx` bits 4i+3..4i.
- R6: Nibble form. When 4·k is at least XLEN, result lane i is zero. On a 32-bit unit that is indices 8 to 15. On a 64-bit unit every index 0 to 15 is in range.
- R7: Lanes are independent. Several lanes may carry the same index, and lanes in range and out of range may be mixed in one word. Each lane still follows R3–R6 on its own.
- R8: While `in_valid` is 0, `out_data` holds its last value. Changes on `op_nib`, `src_tbl` and `src_idx` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the unit |
| in_valid | input | 1 | Operand strobe; loads the result register |
| op_nib | input | 1 | Form select: 0 byte lanes, 1 nibble lanes |
| src_tbl | input | XLEN | Table operand, the source of the elements |
| src_idx | input | XLEN | Index operand, one index per lane |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | XLEN | Registered permuted result |

## Verification
The bench builds two copies of the unit side by side, one with XLEN = 32 and one with XLEN = 64. Both receive the same stimulus; the narrow copy sees the low half. Index nibbles 8 to 15 are therefore zeroed on one copy and selected on the other, which exercises both sides of the R6 bound. Byte indices above 3 land in different out-of-range windows for the two widths. Running back-to-back strobes, idle gaps with scrambled inputs, and a pseudo-random sweep through one reference model checks both width variants of the generated lane selectors.

// File: rtl/xperm_pkg.sv
package xperm_pkg;

  // Element width chosen for one operation.
  typedef enum logic {
    XP_BYTE = 1'b0,
    XP_NIB  = 1'b1
  } xp_form_e;

endpackage

// File: rtl/xperm_lane_sel.sv
// One crossbar: every EW-bit lane of idx selects one EW-bit element of tbl.
// An index that names no element of tbl yields a zero lane.
module xperm_lane_sel #(
  parameter int XLEN = 32,
  parameter int EW   = 8
) (
  input  logic [XLEN-1:0] tbl,
  input  logic [XLEN-1:0] idx,
  output logic [XLEN-1:0] res
);

  localparam int NLANE = XLEN / EW;
  localparam int NCODE = 1 << EW;
  // Elements reachable by an EW-bit index.
  localparam int NSEL  = (NLANE < NCODE) ? NLANE : NCODE;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [EW-1:0] lane_idx;
    logic [EW-1:0] lane_val;

    assign lane_idx = idx[l*EW +: EW];

    always_comb begin
      lane_val = '0;
      for (int k = 0; k < NSEL; k++) begin
        if (lane_idx == EW'(k)) begin
          lane_val = tbl[k*EW +: EW];
        end
      end
    end

    assign res[l*EW +: EW] = lane_val;
  end

endmodule

// File: rtl/xperm_out_reg.sv
// Result register with load enable and valid flag.
module xperm_out_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q,
  output logic            q_vld
);

  logic [XLEN-1:0] q_nxt;
  logic            vld_nxt;

  always_comb begin
    q_nxt   = q;
    vld_nxt = load;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q     <= q_nxt;
      q_vld <= vld_nxt;
    end
  end

endmodule

// File: rtl/xperm_unit.sv
// Byte / nibble crossbar permutation unit, registered output.
module xperm_unit
  import xperm_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            op_nib,
  input  logic [XLEN-1:0] src_tbl,
  input  logic [XLEN-1:0] src_idx,
  output logic            out_valid,
  output logic [XLEN-1:0] out_data
);

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  logic [XLEN-1:0] byte_res;
  logic [XLEN-1:0] nib_res;
  logic [XLEN-1:0] sel_res;
  xp_form_e        form;

  assign form = xp_form_e'(op_nib);

  xperm_lane_sel #(.XLEN(XLEN), .EW(BYTE_W)) u_byte_xbar (
    .tbl (src_tbl),
    .idx (src_idx),
    .res (byte_res)
  );

  xperm_lane_sel #(.XLEN(XLEN), .EW(NIB_W)) u_nib_xbar (
    .tbl (src_tbl),
    .idx (src_idx),
    .res (nib_res)
  );

  always_comb begin
    case (form)
      XP_NIB:  sel_res = nib_res;
      default: sel_res = byte_res;
    endcase
  end

  xperm_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid),
    .d     (sel_res),
    .q     (out_data),
    .q_vld (out_valid)
  );

endmodule

// File: rtl/xperm_unit_chk.sv
// Property checker, bound into every xperm_unit instance.
module xperm_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            op_nib,
  input logic [XLEN-1:0] src_tbl,
  input logic [XLEN-1:0] src_idx,
  input logic            out_valid,
  input logic [XLEN-1:0] out_data
);

  localparam int NBYTE = XLEN / 8;

  // R1: outputs are cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));

  // R2: strobe follows input strobe by one cycle
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2: no strobe without an input strobe
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: result holds while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R4: lane 0 byte index past the table gives zero
  a_r4_byte_oob: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_nib && int'(src_idx[7:0]) >= NBYTE) |=> out_data[7:0] == 8'h00);

  // R3: lane 0 byte index 1 picks table byte 1
  a_r3_byte_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_nib && src_idx[7:0] == 8'd1) |=> out_data[7:0] == $past(src_tbl[15:8]));

  // R5: lane 0 nibble index 1 picks table nibble 1
  a_r5_nib_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_nib && src_idx[3:0] == 4'd1) |=> out_data[3:0] == $past(src_tbl[7:4]));

endmodule

bind xperm_unit xperm_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_nib    (op_nib),
  .src_tbl   (src_tbl),
  .src_idx   (src_idx),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/xperm_unit_test.sv
module xperm_unit_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n;
  logic        in_valid;
  logic        op_nib;
  logic [63:0] tbl;
  logic [63:0] idx;

  logic        ov_n;
  logic [31:0] od_n;
  logic        ov_w;
  logic [63:0] od_w;

  xperm_unit #(.XLEN(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_nib(op_nib),
    .src_tbl(tbl[31:0]), .src_idx(idx[31:0]),
    .out_valid(ov_n), .out_data(od_n)
  );

  xperm_unit #(.XLEN(64)) uut_w (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_nib(op_nib),
    .src_tbl(tbl), .src_idx(idx),
    .out_valid(ov_w), .out_data(od_w)
  );

  typedef struct {
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t        q_n[$];
  exp_t        q_w[$];
  int          checks = 0;
  int          fails  = 0;
  logic [63:0] last_n = '0;
  logic [63:0] last_w = '0;
  bit          mon_en = 1'b0;
  bit          done   = 1'b0;

  // Reference: lane-wise lookup from the requirements (R3-R7).
  function automatic logic [63:0] ref_perm(bit nib, logic [63:0] t, logic [63:0] x, int w);
    logic [63:0] r;
    logic [63:0] m;
    int          ew;
    r  = '0;
    ew = nib ? 4 : 8;
    m  = (64'd1 << ew) - 64'd1;
    for (int l = 0; l < w / ew; l++) begin
      int k;
      k = int'((x >> (l * ew)) & m);
      if (k * ew < w) r |= ((t >> (k * ew)) & m) << (l * ew);
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit nib, logic [63:0] t, logic [63:0] x, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_nib   = nib;
    tbl      = t;
    idx      = x;
    e.tag  = tag;
    e.data = ref_perm(nib, t, x, 32);
    q_n.push_back(e);
    e.data = ref_perm(nib, t, x, 64);
    q_w.push_back(e);
  endtask

  task automatic idle(int n, logic [63:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_nib   = ~op_nib;
      tbl      = junk ^ 64'(i);
      idx      = ~junk;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e;
      if (ov_n) begin
        if (q_n.size() == 0) check(1'b0, "R2 narrow valid without strobe", 64'(ov_n), 64'd0);
        else begin
          e = q_n.pop_front();
          check(od_n == e.data[31:0], {e.tag, " narrow"}, 64'(od_n), e.data);
          last_n = e.data;
        end
      end else begin
        check(od_n == last_n[31:0], "R8 narrow hold", 64'(od_n), last_n);
      end
      if (ov_w) begin
        if (q_w.size() == 0) check(1'b0, "R2 wide valid without strobe", 64'(ov_w), 64'd0);
        else begin
          e = q_w.pop_front();
          check(od_w == e.data, {e.tag, " wide"}, od_w, e.data);
          last_w = e.data;
        end
      end else begin
        check(od_w == last_w, "R8 wide hold", od_w, last_w);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    rst_n    = 1'b1;
    in_valid = 1'b0;
    op_nib   = 1'b0;
    tbl      = '0;
    idx      = '0;
    #1 rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      tbl = 64'hDEAD_BEEF_0000_1111;
      in_valid = 1'b1;   // ignored under reset
      check(!ov_n && od_n == '0, "R1 narrow reset", {31'd0, ov_n, od_n}, 64'd0);
      check(!ov_w && od_w == '0, "R1 wide reset", od_w | 64'(ov_w), 64'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    mon_en   = 1'b1;

    // R3 byte identity and reversal
    drive(1'b0, 64'h8877665544332211, 64'h0706050403020100, "R3 identity");
    drive(1'b0, 64'h8877665544332211, 64'h0001020304050607, "R3 reverse");
    drive(1'b0, 64'hF0E0D0C0B0A09080, 64'h0302010003020100, "R3 repeat");
    // R4 byte out of range
    drive(1'b0, 64'h8877665544332211, 64'h000000FF_FF080403, "R4 oob");
    drive(1'b0, 64'hFFFFFFFFFFFFFFFF, 64'h80402010_0C0B0A04, "R4 oob high");
    idle(2, 64'h1234_5678_9ABC_DEF0);
    // R5 nibble identity, R6 upper nibbles
    drive(1'b1, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210, "R5 identity");
    drive(1'b1, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF, "R5 reverse");
    drive(1'b1, 64'hA5A5A5A5_3C3C3C3C, 64'h89ABCDEF_FEDCBA98, "R6 upper");
    drive(1'b1, 64'h0123456789ABCDEF, 64'h89898989_98989898, "R6 mixed");
    // R7 broadcast and mixed lanes
    drive(1'b0, 64'h8877665544332211, 64'h0202020202020202, "R7 broadcast byte");
    drive(1'b0, 64'h8877665544332211, 64'h00FF010FF0030902, "R7 mixed byte");
    drive(1'b1, 64'h0123456789ABCDEF, 64'h5F5F0A0A_F7070F00, "R7 mixed nibble");
    idle(3, 64'hCAFE_F00D_0BAD_BEEF);
    // Pseudo-random sweep, both forms, with gaps
    s = 64'h1D87_2B41_9C0F_5E36;
    for (int i = 0; i < 48; i++) begin
      logic [63:0] t;
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      t = s ^ {s[31:0], s[63:32]};
      s = {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
      drive(i[0], t, (i % 3 == 0) ? (s & 64'h0707070707070707) : s,
            i[0] ? "R5 R6 random nibble" : "R3 R4 random byte");
      if (i % 7 == 6) idle(1, s);
    end
    idle(3, 64'h0F0F_F0F0_5555_AAAA);
    done = 1'b1;
    check(q_n.size() == 0, "R2 narrow results all delivered", 64'(q_n.size()), 64'd0);
    check(q_w.size() == 0, "R2 wide results all delivered", 64'(q_w.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule